// File: doc/BRIEF.md
# Bit centrifuge unit

This unit splits a 64-bit source word into two groups, steered by a mask word of the same width, and packs the two groups at opposite ends of a single result. Source bits under a clear mask bit gather at the most significant end and source bits under a set mask bit gather at the least significant end. Inside each group the bits keep the relative order they had in the source. No source bit is lost. The two groups always meet with no gap between them.

The operation is a stable partition by mask and not a plain extract. A caller presents a source and a mask with `in_valid`. The result appears one clock later on `out_result` with `out_valid`. The result register keeps its value until the next accepted operation. Width and the structure of the bit-rank counter are parameters.

Numbering used below: "position p" means bit p counted from the most significant end, so position 0 is `in_src[63]` and position 63 is `in_src[0]`. Vector indices such as `out_result[j]` use the usual little-endian numbering.

Top module: `bit_centrifuge`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `out_valid` is 0 and `out_result` is all zeros.
- R2: `out_valid` is 1 in exactly those cycles that follow a clock edge at which `in_valid` was 1. Back-to-back operations give one result per cycle.
- R3: When `in_valid` is 0 at a clock edge, `out_result` keeps its previous value.
- R4: Source bits whose mask bit is 0 are taken from position 0 upward, which is `in_src[63]` downward. They fill result positions 0, 1, 2 and onward, which are `out_result[63]`, `[62]` and onward.
- R5: Source bits whose mask bit is 1 are taken from position 63 downward, which is `in_src[0]` upward. They fill result positions 63, 62 and onward, which are `out_result[0]`, `[1]` and onward.
- R6: If the mask holds k ones, `out_result[k-1:0]` holds exactly the mask-one group and `out_result[63:k]` holds exactly the mask-zero group. The number of ones in the result equals the number of ones in the source. This holds for the boundary cases k=1 and k=63.
- R7: A mask of all zeros returns the source unchanged, and so does a mask of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| in_src | input | 64 | Source word to be partitioned |
| in_mask | input | 64 | Steering mask: 0 sends the bit to the high group, 1 sends it to the low group |
| out_valid | output | 1 | `out_result` holds the result of the operation presented one cycle earlier |
| out_result | output | 64 | Registered partitioned word |

## Verification
The fault to fear is a wrong bit rank. An off-by-one prefix count or a wrong group size shows up in the very next valid result. It appears as a swapped or duplicated bit near the seam between the two groups, so the ones count of the result no longer matches that of the source. Sparse masks with one set or clear bit put that seam at the edges of the word, where an error in the group size would also move the boundary. A lost or stuck valid register shows as an `out_valid` pulse that is missing or extra one cycle after the input edge. A result register that loads when it should not shows in the first idle cycle after an operation.

// File: rtl/bitcfg_pkg.sv
package bitcfg_pkg;
   // Structure used to compute each bit's rank within its group
   typedef enum logic {
      RANK_RIPPLE = 1'b0,   // linear chain of adders, smallest area
      RANK_TREE   = 1'b1    // log-depth parallel prefix, shortest path
   } rank_style_e;
endpackage

// File: rtl/bitcfg_rank.sv
// Exclusive prefix count of selected bits, counted from vector bit 0 upward.
module bitcfg_rank #(
   parameter int W = 64,
   parameter bitcfg_pkg::rank_style_e STYLE = bitcfg_pkg::RANK_TREE,
   localparam int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  sel,
   output logic [CW-1:0] rank [W],
   output logic [CW-1:0] total
);
   localparam int STG = $clog2(W);

   generate
      if (STYLE == bitcfg_pkg::RANK_RIPPLE) begin : g_ripple
         always_comb begin
            logic [CW-1:0] acc;
            acc = '0;
            for (int i = 0; i < W; i++) begin
               rank[i] = acc;
               acc     = acc + CW'(sel[i]);
            end
            total = acc;
         end
      end else begin : g_tree
         logic [CW-1:0] cnt [STG+1][W];
         for (genvar i = 0; i < W; i++) begin : g_init
            assign cnt[0][i] = CW'(sel[i]);
         end
         for (genvar s = 0; s < STG; s++) begin : g_stage
            for (genvar i = 0; i < W; i++) begin : g_cell
               if (i >= (1 << s)) begin : g_add
                  assign cnt[s+1][i] = cnt[s][i] + cnt[s][i-(1<<s)];
               end else begin : g_pass
                  assign cnt[s+1][i] = cnt[s][i];
               end
            end
         end
         for (genvar i = 0; i < W; i++) begin : g_excl
            assign rank[i] = cnt[STG][i] - CW'(sel[i]);
         end
         assign total = cnt[STG][W-1];
      end
   endgenerate
endmodule

// File: rtl/bitcfg_pack.sv
// Packs the selected source bits at the low end, keeping their order.
module bitcfg_pack #(
   parameter int W = 64,
   parameter bitcfg_pkg::rank_style_e STYLE = bitcfg_pkg::RANK_TREE,
   localparam int CW = $clog2(W + 1),
   localparam int IW = $clog2(W)
) (
   input  logic [W-1:0]  src,
   input  logic [W-1:0]  sel,
   output logic [W-1:0]  packed_o,
   output logic [CW-1:0] count_o
);
   logic [CW-1:0] rank [W];

   bitcfg_rank #(.W(W), .STYLE(STYLE)) rank_i (
      .sel   (sel),
      .rank  (rank),
      .total (count_o)
   );

   always_comb begin
      packed_o = '0;
      for (int i = 0; i < W; i++) begin
         if (sel[i]) packed_o[rank[i][IW-1:0]] = src[i];
      end
   end
endmodule

// File: rtl/bit_centrifuge.sv
module bit_centrifuge #(
   parameter int W = 64,
   parameter bitcfg_pkg::rank_style_e RANK_STYLE = bitcfg_pkg::RANK_TREE
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [W-1:0] in_src,
   input  logic [W-1:0] in_mask,
   output logic         out_valid,
   output logic [W-1:0] out_result
);
   localparam int CW = $clog2(W + 1);

   generate
      if (W < 2 || (W & (W - 1)) != 0) begin : g_bad_width
         $error("bit_centrifuge: W must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  low_grp, high_grp, result_d;
   logic [CW-1:0] low_cnt, high_cnt;

   // mask-one bits: packed at the low end
   bitcfg_pack #(.W(W), .STYLE(RANK_STYLE)) low_pack_i (
      .src      (in_src),
      .sel      (in_mask),
      .packed_o (low_grp),
      .count_o  (low_cnt)
   );

   // mask-zero bits: packed low, then lifted above the low group
   bitcfg_pack #(.W(W), .STYLE(RANK_STYLE)) high_pack_i (
      .src      (in_src),
      .sel      (~in_mask),
      .packed_o (high_grp),
      .count_o  (high_cnt)
   );

   always_comb result_d = low_grp | (high_grp << low_cnt);

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_result <= result_d;
      end
   end
endmodule

// File: rtl/bit_centrifuge_chk.sv
module bit_centrifuge_chk #(
   parameter int W = 64
) (
   input logic         clk,
   input logic         rst,
   input logic         in_valid,
   input logic [W-1:0] in_src,
   input logic [W-1:0] in_mask,
   input logic         out_valid,
   input logic [W-1:0] out_result
);
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && out_result == '0));

   p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   p_hold_result_r3: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_result));

   p_bits_kept_r6: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> ($countones(out_result) == $countones($past(in_src))));

   p_identity_mask_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (in_mask == '0 || in_mask == '1)) |=> (out_result == $past(in_src)));
endmodule

bind bit_centrifuge bit_centrifuge_chk #(.W(W)) chk_i (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .in_src     (in_src),
   .in_mask    (in_mask),
   .out_valid  (out_valid),
   .out_result (out_result)
);

// File: tb/bit_centrifuge_tb.sv
`timescale 1ns/1ps
module bit_centrifuge_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [63:0] in_src = '0;
   logic [63:0] in_mask = '0;
   logic        out_valid;
   logic [63:0] out_result;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bit_centrifuge dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src),
      .in_mask(in_mask), .out_valid(out_valid), .out_result(out_result)
   );

   // Reference model written in most-significant-first position order
   function automatic logic [63:0] ref_cfg(input logic [63:0] s, input logic [63:0] m);
      logic [63:0] r;
      int p0, p1;
      r = '0; p0 = 0; p1 = 0;
      for (int p = 0; p < 64; p++) begin
         if (m[63-p] == 1'b0) begin r[63-p0] = s[63-p]; p0++; end
         if (m[p] == 1'b1)    begin r[p1]    = s[p];    p1++; end
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // one operation alone, then one idle cycle
   task automatic single(input string req, input logic [63:0] s, input logic [63:0] m);
      logic [63:0] e;
      e = ref_cfg(s, m);
      @(negedge clk); in_valid = 1'b1; in_src = s; in_mask = m;
      @(negedge clk); in_valid = 1'b0; in_src = ~s; in_mask = ~m;
      check({req, " valid"}, 64'(out_valid), 64'd1);
      check({req, " result"}, out_result, e);
      @(negedge clk);
      check("R2 idle valid", 64'(out_valid), 64'd0);
      check("R3 hold", out_result, e);
   endtask

   initial begin
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      check("R1 reset valid", 64'(out_valid), 64'd0);
      check("R1 reset result", out_result, 64'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 after release", out_result, 64'd0);

      single("R7 zero mask", 64'h0123_4567_89AB_CDEF, 64'd0);
      single("R7 ones mask", 64'hFEDC_BA98_7654_3210, '1);
      // R4: clear mask on top half, src top nibble 1010 -> stays at top
      single("R4 zero group order", 64'hA000_0000_0000_0005, 64'h0000_0000_FFFF_FFFF);
      // R5: only low nibble masked, pattern 0101 kept at bottom
      single("R5 one group order", 64'h5000_0000_0000_0005, 64'h0000_0000_0000_000F);
      // R6 boundaries: single set bit at either end, single clear bit
      single("R6 k=1 top", 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000);
      single("R6 k=1 bottom", 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001);
      single("R6 k=63", 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF);
      single("R6 alternating", 64'hF0F0_F0F0_0F0F_0F0F, 64'hAAAA_AAAA_AAAA_AAAA);

      // R2: back-to-back random stream, one result per cycle
      begin
         logic [63:0] exp_q;
         logic        have;
         have = 1'b0; exp_q = '0;
         for (int n = 0; n < 400; n++) begin
            logic [63:0] s, m;
            s = {$urandom(), $urandom()};
            case (n % 3)
               0: m = {$urandom(), $urandom()};
               1: m = {$urandom(), $urandom()} & {$urandom(), $urandom()};
               default: m = {$urandom(), $urandom()} | {$urandom(), $urandom()};
            endcase
            @(negedge clk);
            if (have) begin
               check("R2 stream valid", 64'(out_valid), 64'd1);
               check("R4 R5 R6 stream result", out_result, exp_q);
               check("R6 ones kept", 64'($countones(out_result)), 64'($countones(exp_q)));
            end
            in_valid = 1'b1; in_src = s; in_mask = m;
            exp_q = ref_cfg(s, m); have = 1'b1;
         end
         @(negedge clk);
         in_valid = 1'b0;
         check("R2 stream last valid", 64'(out_valid), 64'd1);
         check("R6 stream last result", out_result, exp_q);
         @(negedge clk);
         check("R3 hold after stream", out_result, exp_q);
      end
      finish_run();
   end

   initial begin
      #(200000 * 5);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end
endmodule